// File: doc/BRIEF.md
# Exception Entry and Return Unit

This block switches processor state when an exception is taken and when a handler returns. An entry request carries a 6-bit exception code, a 32-bit error word, the address of the next instruction and the current 32-bit state word. The unit decides which save-register pair the exception uses and whether the faulting or the next address is saved. It forms the saved state word and the handler's state word, and it looks up the handler address in a 64-entry vector table combined with a prefix register. It then issues a one-cycle redirect that carries the new program counter and the new state word. The pipeline treats that redirect as a flush.

A return request names a return kind. The unit reads the matching save pair and issues a redirect to the saved address with its two low bits cleared. The new state word is the saved state with a kind-dependent mask removed. The vector table and prefix are loaded through a plain write port. A combinational view port exposes any save pair for inspection.

Both request channels use valid/ready. A request transfers on a rising clock edge where valid and ready are both high. Entry ready is high unless the unit is halted. Return ready is high only when the unit is not halted and no entry request is valid in the same cycle. The redirect output has no ready: the consumer must take it in the cycle it is high.

Top module: `exc_switch`

## Requirements
- R1: On an accepted entry, the saved state equals the current state with mask 0x783F0000 cleared, ORed with the cause bits. For code 4 (instruction storage) the cause bits are the full error word.
- R2: The handler state keeps only bit 12 (machine-check enable) of the current state. Bit 0 (little-endian) is set when bit 16 of the current state is set. Code 2 (machine check) clears bit 12. Code 16 (reset) clears bit 12 unless bit 18 (power-save) is set; in that case bit 12 is kept and cause 0x00010000 is ORed into the saved state.
- R3: Code 7 (program) decodes error bits [3:0]: 1 floating-point, 2 illegal, 3 privileged, 4 trap. These give cause 0x00100000, 0x00080000, 0x00040000 and 0x00020000 respectively. Illegal, privileged and trap entries save the address minus 4. Any other value in error bits [3:0] is an error.
- R4: A floating-point program entry has no effect when bit 13 (FP enable) is 0 or when both bit 11 and bit 8 are 0: no redirect, no error and no save written. When bits 11 and 8 differ, 0x00010000 is ORed into the saved state and the address minus 4 is saved. When they are equal, the next address is saved.
- R5: Codes 6 (alignment), 8 (FP unavailable), 10 (auxiliary unavailable) and 14 (vector unavailable) save the address minus 4. Codes 1, 2, 3, 4, 5, 9, 11, 12, 13, 15 and 16 save the address as given.
- R6: A machine-check entry taken while bit 12 is 0 sets the halted output. Halted holds until reset, and while it is set both ready outputs are low.
- R7: Save pairs are numbered 0 (standard), 1 (critical) and 2 (machine-check). Code 1 always uses pair 1. With split_mck=1, code 13 uses pair 1, and code 2 uses pair 2 and also copies the saved address and state into pair 1. With split_mck=0, code 2 uses pair 1 and code 13 uses pair 0. All other codes use pair 0.
- R8: The handler address is the table entry for the code ORed with the prefix. After reset every entry is all ones and the prefix is 0. The following entries raise err_o for one cycle and change nothing: an entry whose table value is all ones, a code above 16, or a bad program sub-code. Code 0 is accepted with no effect and no error.
- R9: ret_kind selects 0 standard, 1 critical, 2 machine-check, or 3 debug (which reads the critical pair). The return loads the saved address with bits [1:0] cleared. It loads the saved state with 0x783F0000 cleared for kind 0 and with 0x3FFF0000 cleared for the other kinds.
- R10: redirect_o is high for exactly the cycle after an accepted entry or return. An entry valid in the same cycle as a return takes priority, and the return is not accepted.
- R11: tlb_flush_o pulses with the redirect of an entry when bit 5 or bit 4 of the current state is set.
- R12: A cfg_we cycle writes cfg_data into table entry cfg_idx when cfg_prefix is 0, and into the prefix when cfg_prefix is 1. The new value is used by entries accepted from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Entry request valid |
| req_ready | output | 1 | Entry request accepted when high |
| req_code | input | 6 | Exception code |
| req_err | input | 32 | Error word |
| cur_pc | input | 32 | Address of the next instruction |
| cur_state | input | 32 | Current state word |
| split_mck | input | 1 | Selects the separate machine-check pair layout |
| ret_valid | input | 1 | Return request valid |
| ret_ready | output | 1 | Return request accepted when high |
| ret_kind | input | 2 | Return kind |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_prefix | input | 1 | Write the prefix instead of a table entry |
| cfg_idx | input | 6 | Table entry index |
| cfg_data | input | 32 | Configuration write data |
| view_pair | input | 2 | Save pair shown on the view outputs |
| view_addr | output | 32 | Saved address of the viewed pair |
| view_state | output | 32 | Saved state of the viewed pair |
| redirect_o | output | 1 | One-cycle redirect and flush |
| redirect_pc | output | 32 | New program counter |
| redirect_state | output | 32 | New state word |
| tlb_flush_o | output | 1 | Translation flush pulse |
| err_o | output | 1 | Rejected-entry pulse |
| halted_o | output | 1 | Checkstop state |

## Verification
Every result of an accepted request appears one rising edge after the edge that accepts it. That covers the redirect, its address and state, the flush pulse, the error pulse, the halted flag and the save-pair contents. The view port is combinational on top of the save registers. The bench drives requests on the falling edge and samples 1 ns after the accepting rising edge. It then samples again one cycle later to confirm that the pulses have dropped. Cases that must have no effect are judged from the view port, and the redirect and error outputs are checked in the same sampled cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int XLEN    = 32;
  localparam int CODE_W  = 6;
  localparam int NPAIR   = 3;

  localparam logic [XLEN-1:0] SAVE_CLR  = 32'h783F_0000;
  localparam logic [XLEN-1:0] RET_HI_CLR = 32'h3FFF_0000;

  localparam int B_LE  = 0;
  localparam int B_DR  = 4;
  localparam int B_IR  = 5;
  localparam int B_FE1 = 8;
  localparam int B_FE0 = 11;
  localparam int B_ME  = 12;
  localparam int B_FP  = 13;
  localparam int B_ILE = 16;
  localparam int B_POW = 18;

  localparam logic [XLEN-1:0] C_FP_EN  = 32'h0010_0000;
  localparam logic [XLEN-1:0] C_ILL    = 32'h0008_0000;
  localparam logic [XLEN-1:0] C_PRIV   = 32'h0004_0000;
  localparam logic [XLEN-1:0] C_TRAP   = 32'h0002_0000;
  localparam logic [XLEN-1:0] C_FP_IMP = 32'h0001_0000;
  localparam logic [XLEN-1:0] C_WAKE   = 32'h0001_0000;

  typedef enum logic [CODE_W-1:0] {
    EX_NONE = 6'd0,  EX_CRIT = 6'd1,  EX_MCHK = 6'd2,  EX_DSTG = 6'd3,
    EX_ISTG = 6'd4,  EX_EXT  = 6'd5,  EX_ALGN = 6'd6,  EX_PROG = 6'd7,
    EX_FPUN = 6'd8,  EX_SYSC = 6'd9,  EX_AUXU = 6'd10, EX_DECR = 6'd11,
    EX_FTMR = 6'd12, EX_WDOG = 6'd13, EX_VECU = 6'd14, EX_PTMR = 6'd15,
    EX_RST  = 6'd16
  } exc_code_e;

  typedef enum logic [1:0] {
    PAIR_STD = 2'd0, PAIR_CRIT = 2'd1, PAIR_MCK = 2'd2
  } pair_e;

  typedef enum logic [1:0] {
    RET_STD = 2'd0, RET_CRIT = 2'd1, RET_MCK = 2'd2, RET_DBG = 2'd3
  } ret_e;

  typedef struct packed {
    logic            act;
    logic            bad;
    logic            halt;
    logic            dup;
    logic            tlb;
    pair_e           pair;
    logic [XLEN-1:0] sav_addr;
    logic [XLEN-1:0] sav_state;
    logic [XLEN-1:0] new_state;
  } entry_t;
endpackage

// File: rtl/exc_vector_table.sv
module exc_vector_table
  import exc_pkg::*;
#(
  parameter int IDX_W = CODE_W,
  parameter int DW    = XLEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_prefix,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_vec,
  output logic             rd_undef
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] tbl_q [DEPTH];
  logic [DW-1:0] prefix_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prefix_q <= '0;
    else if (wr_en && wr_prefix) prefix_q <= wr_data;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) tbl_q[g] <= '1;
      else if (wr_en && !wr_prefix && wr_idx == IDX_W'(g)) tbl_q[g] <= wr_data;
    end
  end

  assign rd_undef = &tbl_q[rd_idx];
  assign rd_vec   = tbl_q[rd_idx] | prefix_q;
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   err,
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   state,
  input  logic              split_mck,
  output entry_t            ent
);
  logic            use_cur;
  logic [XLEN-1:0] sav;
  logic [XLEN-1:0] nxt;
  localparam logic [XLEN-1:0] ME_M = XLEN'(1) << B_ME;

  always_comb begin
    sav      = state & ~SAVE_CLR;
    nxt      = state & ME_M;
    use_cur  = 1'b0;
    ent.act  = 1'b1;
    ent.bad  = 1'b0;
    ent.halt = 1'b0;
    ent.dup  = 1'b0;
    ent.pair = PAIR_STD;
    case (code)
      EX_NONE: ent.act = 1'b0;
      EX_CRIT: ent.pair = PAIR_CRIT;
      EX_MCHK: begin
        nxt      = '0;
        ent.halt = ~state[B_ME];
        ent.pair = split_mck ? PAIR_MCK : PAIR_CRIT;
        ent.dup  = split_mck;
      end
      EX_WDOG: ent.pair = split_mck ? PAIR_CRIT : PAIR_STD;
      EX_ISTG: sav = sav | err;
      EX_ALGN, EX_FPUN, EX_AUXU, EX_VECU: use_cur = 1'b1;
      EX_DSTG, EX_EXT, EX_SYSC, EX_DECR, EX_FTMR, EX_PTMR: ;
      EX_PROG: begin
        case (err[3:0])
          4'd1: begin
            if (!state[B_FP] || (!state[B_FE0] && !state[B_FE1])) begin
              ent.act = 1'b0;
            end else begin
              sav = sav | C_FP_EN;
              if (state[B_FE0] != state[B_FE1]) begin
                sav     = sav | C_FP_IMP;
                use_cur = 1'b1;
              end
            end
          end
          4'd2: begin sav = sav | C_ILL;  use_cur = 1'b1; end
          4'd3: begin sav = sav | C_PRIV; use_cur = 1'b1; end
          4'd4: begin sav = sav | C_TRAP; use_cur = 1'b1; end
          default: begin ent.act = 1'b0; ent.bad = 1'b1; end
        endcase
      end
      EX_RST: begin
        if (state[B_POW]) sav = sav | C_WAKE;
        else              nxt = '0;
      end
      default: begin ent.act = 1'b0; ent.bad = 1'b1; end
    endcase
    if (state[B_ILE]) nxt[B_LE] = 1'b1;
    ent.sav_state = sav;
    ent.new_state = nxt;
    ent.sav_addr  = use_cur ? pc - XLEN'(4) : pc;
    ent.tlb       = state[B_IR] | state[B_DR];
  end
endmodule

// File: rtl/exc_save_bank.sv
module exc_save_bank
  import exc_pkg::*;
#(
  parameter int DW = XLEN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  pair_e         wr_pair,
  input  logic          wr_dup,
  input  logic [DW-1:0] wr_addr,
  input  logic [DW-1:0] wr_state,
  input  ret_e          ret_kind,
  output logic [DW-1:0] ret_pc,
  output logic [DW-1:0] ret_state,
  input  logic [1:0]    view_pair,
  output logic [DW-1:0] view_addr,
  output logic [DW-1:0] view_state
);
  logic [DW-1:0] a_q [NPAIR];
  logic [DW-1:0] s_q [NPAIR];

  for (genvar g = 0; g < NPAIR; g++) begin : g_pair
    logic hit;
    assign hit = wr_en && ((wr_pair == pair_e'(g)) || (wr_dup && g == int'(PAIR_CRIT)));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        a_q[g] <= '0;
        s_q[g] <= '0;
      end else if (hit) begin
        a_q[g] <= wr_addr;
        s_q[g] <= wr_state;
      end
    end
  end

  logic [1:0]    rsel;
  logic [DW-1:0] rmask;
  always_comb begin
    case (ret_kind)
      RET_STD:  rsel = 2'd0;
      RET_MCK:  rsel = 2'd2;
      default:  rsel = 2'd1;
    endcase
    rmask = (ret_kind == RET_STD) ? SAVE_CLR : RET_HI_CLR;
  end

  assign ret_pc    = {a_q[rsel][DW-1:2], 2'b00};
  assign ret_state = s_q[rsel] & ~rmask;

  assign view_addr  = (view_pair < 2'(NPAIR)) ? a_q[view_pair] : '0;
  assign view_state = (view_pair < 2'(NPAIR)) ? s_q[view_pair] : '0;

  assert_dup_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_dup) |=> (a_q[1] == a_q[2] && s_q[1] == s_q[2]));
endmodule

// File: rtl/exc_switch.sv
module exc_switch
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CODE_W-1:0] req_code,
  input  logic [XLEN-1:0]   req_err,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_state,
  input  logic              split_mck,
  input  logic              ret_valid,
  output logic              ret_ready,
  input  logic [1:0]        ret_kind,
  input  logic              cfg_we,
  input  logic              cfg_prefix,
  input  logic [CODE_W-1:0] cfg_idx,
  input  logic [XLEN-1:0]   cfg_data,
  input  logic [1:0]        view_pair,
  output logic [XLEN-1:0]   view_addr,
  output logic [XLEN-1:0]   view_state,
  output logic              redirect_o,
  output logic [XLEN-1:0]   redirect_pc,
  output logic [XLEN-1:0]   redirect_state,
  output logic              tlb_flush_o,
  output logic              err_o,
  output logic              halted_o
);
  entry_t          ent;
  logic [XLEN-1:0] vec;
  logic            vec_undef;
  logic [XLEN-1:0] r_pc;
  logic [XLEN-1:0] r_state;
  logic            ent_fire, ent_go, ent_bad, ret_fire;

  exc_vector_table #(.IDX_W(CODE_W), .DW(XLEN)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_prefix(cfg_prefix), .wr_idx(cfg_idx), .wr_data(cfg_data),
    .rd_idx(req_code), .rd_vec(vec), .rd_undef(vec_undef)
  );

  exc_entry_calc u_calc (
    .code(req_code), .err(req_err), .pc(cur_pc), .state(cur_state),
    .split_mck(split_mck), .ent(ent)
  );

  assign req_ready = ~halted_o;
  assign ret_ready = ~halted_o & ~req_valid;
  assign ent_fire  = req_valid & req_ready;
  assign ent_go    = ent_fire & ent.act & ~vec_undef;
  assign ent_bad   = ent_fire & (ent.bad | (ent.act & vec_undef));
  assign ret_fire  = ret_valid & ret_ready;

  exc_save_bank #(.DW(XLEN)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ent_go), .wr_pair(ent.pair), .wr_dup(ent.dup),
    .wr_addr(ent.sav_addr), .wr_state(ent.sav_state),
    .ret_kind(ret_e'(ret_kind)), .ret_pc(r_pc), .ret_state(r_state),
    .view_pair(view_pair), .view_addr(view_addr), .view_state(view_state)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redirect_o     <= 1'b0;
      redirect_pc    <= '0;
      redirect_state <= '0;
      tlb_flush_o    <= 1'b0;
      err_o          <= 1'b0;
      halted_o       <= 1'b0;
    end else begin
      redirect_o  <= ent_go | ret_fire;
      tlb_flush_o <= ent_go & ent.tlb;
      err_o       <= ent_bad;
      if (ent_go & ent.halt) halted_o <= 1'b1;
      if (ent_go) begin
        redirect_pc    <= vec;
        redirect_state <= ent.new_state;
      end else if (ret_fire) begin
        redirect_pc    <= r_pc;
        redirect_state <= r_state;
      end
    end
  end

  assert_redirect_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> $past(ent_go || ret_fire));
  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(redirect_o && err_o));
  assert_halt_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> halted_o);
  assert_halt_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |-> (!req_ready && !ret_ready));
  assert_entry_state_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ent_go |=> ((redirect_state & ~((XLEN'(1) << B_ME) | (XLEN'(1) << B_LE))) == '0));
  assert_ret_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |=> (redirect_o && redirect_pc[1:0] == 2'b00));
  assert_mck_halt_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_go && req_code == EX_MCHK && !cur_state[B_ME]) |=> halted_o);
endmodule

// File: tb/exc_switch_tb.sv
module exc_switch_tb;
  localparam int CLK_P = 10;
  localparam logic [31:0] PFX = 32'hFFF0_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [5:0]  req_code = '0;
  logic [31:0] req_err = '0, cur_pc = '0, cur_state = '0;
  logic        split_mck = 1'b0;
  logic        ret_valid = 1'b0, ret_ready;
  logic [1:0]  ret_kind = '0;
  logic        cfg_we = 1'b0, cfg_prefix = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic [1:0]  view_pair = '0;
  logic [31:0] view_addr, view_state, redirect_pc, redirect_state;
  logic        redirect_o, tlb_flush_o, err_o, halted_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  exc_switch u_dut (
    .clk, .rst_n, .req_valid, .req_ready, .req_code, .req_err, .cur_pc, .cur_state,
    .split_mck, .ret_valid, .ret_ready, .ret_kind, .cfg_we, .cfg_prefix, .cfg_idx,
    .cfg_data, .view_pair, .view_addr, .view_state, .redirect_o, .redirect_pc,
    .redirect_state, .tlb_flush_o, .err_o, .halted_o
  );

  typedef struct packed {
    logic [5:0]  code;
    logic [31:0] err, pc, st, e_pc, e_st, e_sa, e_ss;
    logic        e_tlb;
  } row_t;

  localparam int NROW = 14;
  localparam row_t ROWS [NROW] = '{
    '{6'd5,  32'h0, 32'h1000, 32'h0000_9000, PFX|32'h500,  32'h1000, 32'h1000, 32'h0000_9000, 1'b0},
    '{6'd6,  32'h0, 32'h2004, 32'hFFFF_FFFF, PFX|32'h600,  32'h1001, 32'h2000, 32'h87C0_FFFF, 1'b1},
    '{6'd7,  32'h2, 32'h3000, 32'h0,         PFX|32'h700,  32'h0,    32'h2FFC, 32'h0008_0000, 1'b0},
    '{6'd7,  32'h3, 32'h3000, 32'h1000,      PFX|32'h700,  32'h1000, 32'h2FFC, 32'h0004_1000, 1'b0},
    '{6'd7,  32'h4, 32'h3100, 32'h0,         PFX|32'h700,  32'h0,    32'h30FC, 32'h0002_0000, 1'b0},
    '{6'd7,  32'h1, 32'h3200, 32'h2800,      PFX|32'h700,  32'h0,    32'h31FC, 32'h0011_2800, 1'b0},
    '{6'd7,  32'h1, 32'h3300, 32'h2900,      PFX|32'h700,  32'h0,    32'h3300, 32'h0010_2900, 1'b0},
    '{6'd9,  32'h0, 32'h4000, 32'h4000_1000, PFX|32'h900,  32'h1000, 32'h4000, 32'h0000_1000, 1'b0},
    '{6'd4,  32'h4000_0000, 32'h4100, 32'h10, PFX|32'h400, 32'h0,    32'h4100, 32'h4000_0010, 1'b1},
    '{6'd11, 32'h0, 32'h4200, 32'h0001_8000, PFX|32'hB00,  32'h1,    32'h4200, 32'h0000_8000, 1'b0},
    '{6'd16, 32'h0, 32'h4300, 32'h0004_1000, PFX|32'h1000, 32'h1000, 32'h4300, 32'h0001_1000, 1'b0},
    '{6'd16, 32'h0, 32'h4400, 32'h1000,      PFX|32'h1000, 32'h0,    32'h4400, 32'h0000_1000, 1'b0},
    '{6'd8,  32'h0, 32'h4504, 32'h1020,      PFX|32'h800,  32'h1000, 32'h4500, 32'h0000_1020, 1'b1},
    '{6'd14, 32'h0, 32'h4600, 32'h0,         PFX|32'hE00,  32'h0,    32'h45FC, 32'h0,         1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cfg(input logic pfx, input logic [5:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_prefix = pfx; cfg_idx = idx; cfg_data = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic setup_table();
    cfg(1'b1, 6'd0, PFX);
    for (int c = 1; c <= 16; c++)
      if (c != 12) cfg(1'b0, 6'(c), 32'(c) << 8);
  endtask

  task automatic ent(input logic [5:0] code, input logic [31:0] err, input logic [31:0] pc,
                     input logic [31:0] st, input logic split);
    @(negedge clk);
    req_valid = 1'b1; req_code = code; req_err = err; cur_pc = pc; cur_state = st;
    split_mck = split;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic ret(input logic [1:0] kind);
    @(negedge clk);
    ret_valid = 1'b1; ret_kind = kind;
    @(posedge clk); #1;
    ret_valid = 1'b0;
  endtask

  task automatic view(input logic [1:0] p);
    view_pair = p; #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    do_reset();
    #1;
    // R6 R10 reset state
    chk("R10 reset redirect", 32'(redirect_o), 32'h0);
    chk("R6 reset halted", 32'(halted_o), 32'h0);
    chk("R6 reset ready", 32'(req_ready), 32'h1);
    // R8 table all ones after reset
    ent(6'd5, 0, 32'h100, 0, 1'b0);
    chk("R8 undefined vector err", 32'(err_o), 32'h1);
    chk("R8 undefined vector no redirect", 32'(redirect_o), 32'h0);

    setup_table();

    for (int i = 0; i < NROW; i++) begin
      ent(ROWS[i].code, ROWS[i].err, ROWS[i].pc, ROWS[i].st, 1'b0);
      view(2'd0);
      chk($sformatf("R10 row%0d redirect", i), 32'(redirect_o), 32'h1);
      chk($sformatf("R8 row%0d handler pc", i), redirect_pc, ROWS[i].e_pc);
      chk($sformatf("R2 row%0d new state", i), redirect_state, ROWS[i].e_st);
      chk($sformatf("R5 R3 row%0d saved addr", i), view_addr, ROWS[i].e_sa);
      chk($sformatf("R1 R4 row%0d saved state", i), view_state, ROWS[i].e_ss);
      chk($sformatf("R11 row%0d tlb flush", i), 32'(tlb_flush_o), 32'(ROWS[i].e_tlb));
    end
    @(posedge clk); #1;
    chk("R10 pulse drops", 32'(redirect_o), 32'h0);

    // R4 dropped FP entries
    ent(6'd7, 32'h1, 32'h7000, 32'h2000, 1'b0);
    view(2'd0);
    chk("R4 drop fe both zero redirect", 32'(redirect_o), 32'h0);
    chk("R4 drop no err", 32'(err_o), 32'h0);
    chk("R4 drop save untouched", view_addr, 32'h45FC);
    ent(6'd7, 32'h1, 32'h7000, 32'h0900, 1'b0);
    chk("R4 drop fp off redirect", 32'(redirect_o), 32'h0);
    chk("R4 drop fp off save", view_addr, 32'h45FC);

    // R8 invalid cases
    ent(6'd0, 0, 32'h7100, 0, 1'b0);
    chk("R8 code0 redirect", 32'(redirect_o), 32'h0);
    chk("R8 code0 err", 32'(err_o), 32'h0);
    ent(6'd12, 0, 32'h7100, 0, 1'b0);
    chk("R8 unset entry err", 32'(err_o), 32'h1);
    ent(6'd40, 0, 32'h7100, 0, 1'b0);
    chk("R8 unknown code err", 32'(err_o), 32'h1);
    ent(6'd7, 32'h7, 32'h7100, 0, 1'b0);
    chk("R3 bad subcode err", 32'(err_o), 32'h1);
    view(2'd0);
    chk("R8 errors leave save", view_addr, 32'h45FC);

    // R12 config write then use
    cfg(1'b0, 6'd12, 32'hC00);
    ent(6'd12, 0, 32'h7200, 0, 1'b0);
    chk("R12 written entry used", redirect_pc, PFX | 32'hC00);

    // R9 standard return
    ent(6'd4, 32'h0020_0000, 32'h4102, 32'h10, 1'b0);
    ret(2'd0);
    chk("R9 std ret pc", redirect_pc, 32'h4100);
    chk("R9 std ret state", redirect_state, 32'h0000_0010);

    // R7 critical with split
    ent(6'd1, 0, 32'h5007, 32'hFFFF_FFFF, 1'b1);
    view(2'd1);
    chk("R7 crit pair addr", view_addr, 32'h5007);
    chk("R7 crit pair state", view_state, 32'h87C0_FFFF);
    view(2'd0);
    chk("R7 std pair untouched", view_addr, 32'h4102);
    ret(2'd1);
    chk("R9 crit ret pc", redirect_pc, 32'h5004);
    chk("R9 crit ret state", redirect_state, 32'h8000_FFFF);
    ret(2'd3);
    chk("R9 debug ret state", redirect_state, 32'h8000_FFFF);

    // R7 machine check split copies into crit pair
    ent(6'd2, 0, 32'h6000, 32'h1000, 1'b1);
    chk("R2 mchk clears enable", redirect_state, 32'h0);
    chk("R6 mchk enabled no halt", 32'(halted_o), 32'h0);
    view(2'd2);
    chk("R7 mck pair addr", view_addr, 32'h6000);
    view(2'd1);
    chk("R7 dup into crit pair", view_addr, 32'h6000);
    ret(2'd2);
    chk("R9 mck ret pc", redirect_pc, 32'h6000);
    chk("R9 mck ret state", redirect_state, 32'h1000);
    ent(6'd2, 0, 32'h6100, 32'h1000, 1'b0);
    view(2'd1);
    chk("R7 mchk unsplit crit pair", view_addr, 32'h6100);
    view(2'd2);
    chk("R7 mchk unsplit mck untouched", view_addr, 32'h6000);

    // R10 entry wins over return
    @(negedge clk);
    req_valid = 1'b1; req_code = 6'd5; cur_pc = 32'h7300; cur_state = 0;
    ret_valid = 1'b1; ret_kind = 2'd0;
    #1;
    chk("R10 ret blocked by entry", 32'(ret_ready), 32'h0);
    @(posedge clk); #1;
    req_valid = 1'b0; ret_valid = 1'b0;
    chk("R10 entry priority pc", redirect_pc, PFX | 32'h500);

    // R6 checkstop
    ent(6'd2, 0, 32'h6200, 32'h0, 1'b0);
    chk("R6 halted set", 32'(halted_o), 32'h1);
    chk("R6 req ready low", 32'(req_ready), 32'h0);
    ent(6'd5, 0, 32'h6300, 0, 1'b0);
    chk("R6 halted no redirect", 32'(redirect_o), 32'h0);
    view(2'd0);
    chk("R6 halted save untouched", view_addr, 32'h7300);
    do_reset();
    #1;
    chk("R6 reset clears halt", 32'(halted_o), 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule